// File: doc/BRIEF.md
# LPC and Firmware Hub Address Decoder

This block sits in a host bridge and decides, for every host cycle, whether the cycle belongs on the low pin count (LPC) bus. It holds two configuration registers. The first is a 16-bit register of I/O window enables, one bit per legacy device range. The second is an 8-bit register of firmware hub enables, two bits of which open memory windows at the top of the 4 GB space, in a register window 4 MB lower, and in a 128 KB shadow just below 1 MB.

Both claim flags are combinational from the cycle address and the memory/I/O type flag. The bridge's cycle logic samples them to route the cycle. The firmware hub register is not a fixed reset value. When power-good rises, the block samples a strap pin and fills the register with all ones or all zeros from it. After that, software can change it through the configuration port.

The configuration port works on aligned 16-bit words. The byte address must be even, and its word holds the byte at that address in the low lane and the next byte in the high lane. Two byte enables gate the lanes.

Top module: `lpc_fwh_decoder`

## Requirements
- R1: After rst_ni is asserted, the I/O enable word (byte address E6h) reads 0000h and the firmware hub byte (E3h, high lane of word E2h) reads 00h. With no enables set, no cycle is claimed.
- R2: A write to byte address E6h updates byte E6h only when cfg_be_i[0]=1 and byte E7h only when cfg_be_i[1]=1. Bits 15:13 always read 0. A write to an odd byte address or to an unmapped word changes nothing, and a read of an unmapped or odd address returns 0.
- R3: With the enable bit set, the following I/O cycles are claimed: bit 12 claims ports 4Eh–4Fh, bit 11 claims 2Eh–2Fh, bit 10 claims ports 62h and 66h only, and bit 8 claims ports 60h and 64h only.
- R4: Bit 7 claims I/O 200h–20Fh, and bit 6 claims I/O 388h–38Bh.
- R5: The following windows are claimed: bit 9 claims 530h–537h, bit 5 claims 330h–331h, bit 4 claims 220h–233h, bit 3 claims 3F0h–3F5h and 3F7h (not 3F6h), bit 2 claims 378h–37Fh, bit 1 claims 2F8h–2FFh, and bit 0 claims 3F8h–3FFh.
- R6: lpc_io_hit_o is the OR of all enabled window matches. It compares only cyc_addr_i[15:0] and is never set for a memory cycle (cyc_is_mem_i=1).
- R7: When E3h bit 7 is set, memory cycles to FFF80000h–FFFFFFFFh, FFB80000h–FFBFFFFFh and 000E0000h–000FFFFFh raise fwh_mem_hit_o.
- R8: When E3h bit 6 is set, memory cycles to FFF00000h–FFF7FFFFh and FFB00000h–FFB7FFFFh raise fwh_mem_hit_o.
- R9: In the clock after pwr_good_i is first seen high following a low, E3h is loaded with 00h if strap_i was 1, or with FFh if strap_i was 0. While pwr_good_i stays high, strap_i has no effect.
- R10: A configuration write overrides E3h until the next power-good rise. E3h bits 5:0 read back as stored but do not affect decoding, and fwh_mem_hit_o is never set for an I/O cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_good_i | input | 1 | Power-good; a rise triggers the strap load |
| strap_i | input | 1 | Firmware-absent strap (1 = absent) |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 8 | Configuration byte address (even) |
| cfg_be_i | input | 2 | Byte enables, bit 0 = low lane |
| cfg_wdata_i | input | 16 | Configuration write data |
| cfg_rdata_o | output | 16 | Configuration read data (combinational) |
| cyc_addr_i | input | 32 | Host cycle address |
| cyc_is_mem_i | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| lpc_io_hit_o | output | 1 | I/O cycle claimed for LPC |
| fwh_mem_hit_o | output | 1 | Memory cycle claimed as firmware hub |

## Verification
The assertions check on every cycle that the type gating holds, that the reserved top bits of the I/O word stay 0, that a power-good rise loads the strap-derived value, and that E3h holds when there is neither a rise nor a write. Only the bench scenarios can show the exact window edges for each enable bit, the split byte-lane writes, and the order of strap load followed by a software override. Those scenarios also cover the 3F6h hole and the case where a held power-good ignores the strap.

// File: rtl/lpc_fwh_pkg.sv
package lpc_fwh_pkg;
  localparam int IO_EN_W   = 16;
  localparam int FWH_EN_W  = 8;
  localparam int IO_AW     = 16;
  localparam int MEM_AW    = 32;
  localparam int N_IO_WIN  = 13;
  localparam int N_PART    = 2;
  localparam int CFG_AW    = 8;

  localparam logic [CFG_AW-1:0]  IO_EN_ADDR  = 8'hE6;
  localparam logic [CFG_AW-1:0]  FWH_EN_ADDR = 8'hE2; // E3h sits in the high lane
  localparam logic [IO_EN_W-1:0] IO_EN_WMASK = 16'h1FFF;

  typedef struct packed {
    logic [IO_AW-1:0] lo;
    logic [IO_AW-1:0] hi;
  } io_win_t;

  localparam io_win_t WIN_NONE = '{lo: 16'hFFFF, hi: 16'h0000};

  function automatic io_win_t mk(logic [IO_AW-1:0] lo, logic [IO_AW-1:0] hi);
    io_win_t w;
    w.lo = lo;
    w.hi = hi;
    return w;
  endfunction

  // Window table: enable bit index, part index
  function automatic io_win_t io_win(int b, int p);
    io_win_t w;
    w = WIN_NONE;
    case (b)
      0:  if (p == 0) w = mk(16'h03F8, 16'h03FF);
      1:  if (p == 0) w = mk(16'h02F8, 16'h02FF);
      2:  if (p == 0) w = mk(16'h0378, 16'h037F);
      3:  w = (p == 0) ? mk(16'h03F0, 16'h03F5) : mk(16'h03F7, 16'h03F7);
      4:  if (p == 0) w = mk(16'h0220, 16'h0233);
      5:  if (p == 0) w = mk(16'h0330, 16'h0331);
      6:  if (p == 0) w = mk(16'h0388, 16'h038B);
      7:  if (p == 0) w = mk(16'h0200, 16'h020F);
      8:  w = (p == 0) ? mk(16'h0060, 16'h0060) : mk(16'h0064, 16'h0064);
      9:  if (p == 0) w = mk(16'h0530, 16'h0537);
      10: w = (p == 0) ? mk(16'h0062, 16'h0062) : mk(16'h0066, 16'h0066);
      11: if (p == 0) w = mk(16'h002E, 16'h002F);
      12: if (p == 0) w = mk(16'h004E, 16'h004F);
      default: w = WIN_NONE;
    endcase
    return w;
  endfunction

  // Firmware hub windows, compared on address bits above the window size
  localparam int HI512_LSB = 19;
  localparam int HI128_LSB = 17;
  localparam logic [MEM_AW-1:HI512_LSB] F8_TOP   = 13'h1FFF; // FFF80000h
  localparam logic [MEM_AW-1:HI512_LSB] F8_REG   = 13'h1FF7; // FFB80000h
  localparam logic [MEM_AW-1:HI512_LSB] F0_TOP   = 13'h1FFE; // FFF00000h
  localparam logic [MEM_AW-1:HI512_LSB] F0_REG   = 13'h1FF6; // FFB00000h
  localparam logic [MEM_AW-1:HI128_LSB] F8_SHADOW = 15'h0007; // 000E0000h
endpackage

// File: rtl/lpc_fwh_cfg_regs.sv
module lpc_fwh_cfg_regs
  import lpc_fwh_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 pwr_good_i,
  input  logic                 strap_i,
  input  logic                 cfg_wr_i,
  input  logic [CFG_AW-1:0]    cfg_addr_i,
  input  logic [1:0]           cfg_be_i,
  input  logic [IO_EN_W-1:0]   cfg_wdata_i,
  output logic [IO_EN_W-1:0]   cfg_rdata_o,
  output logic [IO_EN_W-1:0]   io_en_o,
  output logic [1:0]           fwh_dec_en_o
);
  logic [IO_EN_W-1:0]  io_en_q;
  logic [FWH_EN_W-1:0] fwh_en_q;
  logic                pg_q;
  logic                pg_rise;
  logic                sel_io, sel_fwh;
  logic                wr_fwh;

  assign pg_rise = pwr_good_i && !pg_q;
  assign sel_io  = (cfg_addr_i == IO_EN_ADDR);
  assign sel_fwh = (cfg_addr_i == FWH_EN_ADDR);
  assign wr_fwh  = cfg_wr_i && sel_fwh && cfg_be_i[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pg_q <= 1'b0;
    else         pg_q <= pwr_good_i;
  end

  generate
    for (genvar l = 0; l < 2; l++) begin : g_io_lane
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
          io_en_q[l*8 +: 8] <= '0;
        else if (cfg_wr_i && sel_io && cfg_be_i[l])
          io_en_q[l*8 +: 8] <= cfg_wdata_i[l*8 +: 8] & IO_EN_WMASK[l*8 +: 8];
      end
    end
  endgenerate

  // Strap load wins over a same-cycle write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      fwh_en_q <= '0;
    else if (pg_rise) fwh_en_q <= strap_i ? '0 : '1;
    else if (wr_fwh)  fwh_en_q <= cfg_wdata_i[15:8];
  end

  always_comb begin
    cfg_rdata_o = '0;
    if (sel_io)       cfg_rdata_o = io_en_q;
    else if (sel_fwh) cfg_rdata_o = {fwh_en_q, 8'h00};
  end

  assign io_en_o      = io_en_q;
  assign fwh_dec_en_o = fwh_en_q[7:6];

  p_rsvd_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_en_q[15:13] == 3'b000);

  p_strap_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_good_i && !pg_q) |=> (fwh_en_q == ($past(strap_i) ? 8'h00 : 8'hFF)));

  p_fwh_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(pwr_good_i && !pg_q) && !(cfg_wr_i && cfg_addr_i == FWH_EN_ADDR && cfg_be_i[1]))
      |=> $stable(fwh_en_q));
endmodule

// File: rtl/lpc_io_decode.sv
module lpc_io_decode
  import lpc_fwh_pkg::*;
#(
  parameter int NW = N_IO_WIN,
  parameter int NP = N_PART
) (
  input  logic [IO_AW-1:0]   io_addr_i,
  input  logic [NW-1:0]      en_i,
  output logic               hit_o
);
  logic [NW-1:0] win_any;

  generate
    for (genvar b = 0; b < NW; b++) begin : g_win
      logic [NP-1:0] part_hit;
      for (genvar p = 0; p < NP; p++) begin : g_part
        localparam io_win_t W = io_win(b, p);
        assign part_hit[p] = (io_addr_i >= W.lo) && (io_addr_i <= W.hi);
      end
      assign win_any[b] = |part_hit;
    end
  endgenerate

  assign hit_o = |(win_any & en_i);
endmodule

// File: rtl/fwh_mem_decode.sv
module fwh_mem_decode
  import lpc_fwh_pkg::*;
(
  input  logic [MEM_AW-1:0] mem_addr_i,
  input  logic [1:0]        en_i,       // [1]: upper 512K set, [0]: lower 512K set
  output logic              hit_o
);
  logic [MEM_AW-1:HI512_LSB] a512;
  logic [MEM_AW-1:HI128_LSB] a128;
  logic                      f8_hit, f0_hit;

  assign a512   = mem_addr_i[MEM_AW-1:HI512_LSB];
  assign a128   = mem_addr_i[MEM_AW-1:HI128_LSB];
  assign f8_hit = (a512 == F8_TOP) || (a512 == F8_REG) || (a128 == F8_SHADOW);
  assign f0_hit = (a512 == F0_TOP) || (a512 == F0_REG);
  assign hit_o  = (en_i[1] && f8_hit) || (en_i[0] && f0_hit);
endmodule

// File: rtl/lpc_fwh_decoder.sv
module lpc_fwh_decoder
  import lpc_fwh_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                pwr_good_i,
  input  logic                strap_i,
  input  logic                cfg_wr_i,
  input  logic [CFG_AW-1:0]   cfg_addr_i,
  input  logic [1:0]          cfg_be_i,
  input  logic [IO_EN_W-1:0]  cfg_wdata_i,
  output logic [IO_EN_W-1:0]  cfg_rdata_o,
  input  logic [MEM_AW-1:0]   cyc_addr_i,
  input  logic                cyc_is_mem_i,
  output logic                lpc_io_hit_o,
  output logic                fwh_mem_hit_o
);
  logic [IO_EN_W-1:0] io_en;
  logic [1:0]         fwh_en;
  logic               io_raw, mem_raw;

  lpc_fwh_cfg_regs u_regs (
    .clk_i, .rst_ni, .pwr_good_i, .strap_i,
    .cfg_wr_i, .cfg_addr_i, .cfg_be_i, .cfg_wdata_i, .cfg_rdata_o,
    .io_en_o(io_en), .fwh_dec_en_o(fwh_en)
  );

  lpc_io_decode #(.NW(N_IO_WIN), .NP(N_PART)) u_io (
    .io_addr_i(cyc_addr_i[IO_AW-1:0]),
    .en_i     (io_en[N_IO_WIN-1:0]),
    .hit_o    (io_raw)
  );

  fwh_mem_decode u_mem (
    .mem_addr_i(cyc_addr_i),
    .en_i      (fwh_en),
    .hit_o     (mem_raw)
  );

  assign lpc_io_hit_o  = io_raw && !cyc_is_mem_i;
  assign fwh_mem_hit_o = mem_raw && cyc_is_mem_i;

  p_io_not_mem_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_is_mem_i |-> !lpc_io_hit_o);

  p_mem_not_io_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cyc_is_mem_i |-> !fwh_mem_hit_o);

  p_io_needs_en_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_en == '0) |-> !lpc_io_hit_o);

  p_mem_needs_en_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwh_en == 2'b00) |-> !fwh_mem_hit_o);
endmodule

// File: tb/tb_lpc_fwh_decoder.sv
module tb_lpc_fwh_decoder;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pwr_good_i = 1'b0;
  logic        strap_i = 1'b0;
  logic        cfg_wr_i = 1'b0;
  logic [7:0]  cfg_addr_i = 8'h00;
  logic [1:0]  cfg_be_i = 2'b00;
  logic [15:0] cfg_wdata_i = 16'h0000;
  logic [15:0] cfg_rdata_o;
  logic [31:0] cyc_addr_i = 32'h0;
  logic        cyc_is_mem_i = 1'b0;
  logic        lpc_io_hit_o, fwh_mem_hit_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk_i = ~clk_i;

  lpc_fwh_decoder dut (.*);

  typedef struct packed {
    logic [15:0] io_en;
    logic [7:0]  fwh_en;
    logic        is_mem;
    logic [31:0] addr;
    logic        exp_io;
    logic        exp_mem;
  } vec_t;

  localparam int NV = 36;
  localparam vec_t VECS [NV] = '{
    '{16'h1000, 8'h00, 1'b0, 32'h0000004E, 1'b1, 1'b0}, // R3
    '{16'h1000, 8'h00, 1'b0, 32'h00000050, 1'b0, 1'b0}, // R3
    '{16'h0800, 8'h00, 1'b0, 32'h0000002F, 1'b1, 1'b0}, // R3
    '{16'h0400, 8'h00, 1'b0, 32'h00000066, 1'b1, 1'b0}, // R3
    '{16'h0400, 8'h00, 1'b0, 32'h00000064, 1'b0, 1'b0}, // R3
    '{16'h0100, 8'h00, 1'b0, 32'h00000064, 1'b1, 1'b0}, // R3
    '{16'h0100, 8'h00, 1'b0, 32'h00000062, 1'b0, 1'b0}, // R3
    '{16'h0080, 8'h00, 1'b0, 32'h0000020F, 1'b1, 1'b0}, // R4
    '{16'h0080, 8'h00, 1'b0, 32'h00000210, 1'b0, 1'b0}, // R4
    '{16'h0040, 8'h00, 1'b0, 32'h00000388, 1'b1, 1'b0}, // R4
    '{16'h0040, 8'h00, 1'b0, 32'h0000038C, 1'b0, 1'b0}, // R4
    '{16'h0200, 8'h00, 1'b0, 32'h00000537, 1'b1, 1'b0}, // R5
    '{16'h0020, 8'h00, 1'b0, 32'h00000331, 1'b1, 1'b0}, // R5
    '{16'h0010, 8'h00, 1'b0, 32'h00000233, 1'b1, 1'b0}, // R5
    '{16'h0010, 8'h00, 1'b0, 32'h00000234, 1'b0, 1'b0}, // R5
    '{16'h0008, 8'h00, 1'b0, 32'h000003F7, 1'b1, 1'b0}, // R5
    '{16'h0008, 8'h00, 1'b0, 32'h000003F6, 1'b0, 1'b0}, // R5 hole
    '{16'h0004, 8'h00, 1'b0, 32'h00000378, 1'b1, 1'b0}, // R5
    '{16'h0002, 8'h00, 1'b0, 32'h000002F8, 1'b1, 1'b0}, // R5
    '{16'h0001, 8'h00, 1'b0, 32'h000003FF, 1'b1, 1'b0}, // R5
    '{16'h0001, 8'h00, 1'b1, 32'h000003FF, 1'b0, 1'b0}, // R6 mem type
    '{16'h1FFF, 8'h00, 1'b0, 32'h010003F8, 1'b1, 1'b0}, // R6 upper ignored
    '{16'h1FFE, 8'h00, 1'b0, 32'h000003F8, 1'b0, 1'b0}, // R6
    '{16'h0000, 8'h00, 1'b0, 32'h000003F8, 1'b0, 1'b0}, // R1
    '{16'h0000, 8'h80, 1'b1, 32'hFFF80000, 1'b0, 1'b1}, // R7
    '{16'h0000, 8'h80, 1'b1, 32'h000FFFFF, 1'b0, 1'b1}, // R7
    '{16'h0000, 8'h80, 1'b1, 32'h000DFFFF, 1'b0, 1'b0}, // R7
    '{16'h0000, 8'h80, 1'b1, 32'hFFBFFFFF, 1'b0, 1'b1}, // R7
    '{16'h0000, 8'h80, 1'b1, 32'hFFB7FFFF, 1'b0, 1'b0}, // R7
    '{16'h0000, 8'h40, 1'b1, 32'hFFF7FFFF, 1'b0, 1'b1}, // R8
    '{16'h0000, 8'h40, 1'b1, 32'hFFB00000, 1'b0, 1'b1}, // R8
    '{16'h0000, 8'h40, 1'b1, 32'hFFF80000, 1'b0, 1'b0}, // R8
    '{16'h0000, 8'h40, 1'b1, 32'h000E0000, 1'b0, 1'b0}, // R8
    '{16'h0000, 8'h3F, 1'b1, 32'hFFF80000, 1'b0, 1'b0}, // R10 reserved bits
    '{16'h0000, 8'hC0, 1'b0, 32'hFFF80000, 1'b0, 1'b0}, // R10 io type
    '{16'h0000, 8'hC0, 1'b1, 32'hFFEFFFFF, 1'b0, 1'b0}  // R8 below window
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(logic [7:0] a, logic [1:0] be, logic [15:0] d);
    @(negedge clk_i);
    cfg_wr_i = 1'b1; cfg_addr_i = a; cfg_be_i = be; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_wr_i = 1'b0; cfg_be_i = 2'b00;
  endtask

  task automatic cfg_read(logic [7:0] a, output logic [15:0] d);
    cfg_addr_i = a;
    #1;
    d = cfg_rdata_o;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] rd;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    cfg_read(8'hE6, rd); chk("R1 io word", rd, 16'h0000);
    cfg_read(8'hE2, rd); chk("R1 fwh byte", rd, 16'h0000);
    cyc_addr_i = 32'h000003F8; cyc_is_mem_i = 1'b0; #1;
    chk("R1 no io hit", lpc_io_hit_o, 1'b0);
    cyc_addr_i = 32'hFFF80000; cyc_is_mem_i = 1'b1; #1;
    chk("R1 no mem hit", fwh_mem_hit_o, 1'b0);

    // R2 byte lanes and masks
    cfg_write(8'hE6, 2'b01, 16'hFFFF);
    cfg_read(8'hE6, rd); chk("R2 low lane", rd, 16'h00FF);
    cfg_write(8'hE6, 2'b10, 16'hFF00);
    cfg_read(8'hE6, rd); chk("R2 high lane, 15:13 zero", rd, 16'h1FFF);
    cfg_write(8'hE7, 2'b11, 16'h0000);
    cfg_read(8'hE6, rd); chk("R2 odd address write ignored", rd, 16'h1FFF);
    cfg_write(8'h40, 2'b11, 16'h0000);
    cfg_read(8'hE6, rd); chk("R2 unmapped write ignored", rd, 16'h1FFF);
    cfg_read(8'hE7, rd); chk("R2 odd read zero", rd, 16'h0000);
    cfg_read(8'h40, rd); chk("R2 unmapped read zero", rd, 16'h0000);

    // Vector table: R3..R8, R10
    for (int i = 0; i < NV; i++) begin
      cfg_write(8'hE6, 2'b11, VECS[i].io_en);
      cfg_write(8'hE2, 2'b10, {VECS[i].fwh_en, 8'h00});
      cyc_addr_i   = VECS[i].addr;
      cyc_is_mem_i = VECS[i].is_mem;
      #1;
      chk($sformatf("R3-R10 vec %0d io", i), lpc_io_hit_o, VECS[i].exp_io);
      chk($sformatf("R3-R10 vec %0d mem", i), fwh_mem_hit_o, VECS[i].exp_mem);
    end

    // R10 reserved bits read back
    cfg_write(8'hE2, 2'b10, 16'h2500);
    cfg_read(8'hE2, rd); chk("R10 reserved readback", rd, 16'h2500);

    // R9 strap 0 -> all ones
    strap_i = 1'b0;
    @(negedge clk_i); pwr_good_i = 1'b1;
    @(negedge clk_i);
    cfg_read(8'hE2, rd); chk("R9 strap0 loads FF", rd, 16'hFF00);

    // R10 override, then R9 strap ignored while power-good held
    cfg_write(8'hE2, 2'b10, 16'h1200);
    cfg_read(8'hE2, rd); chk("R10 override", rd, 16'h1200);
    strap_i = 1'b1;
    repeat (3) @(negedge clk_i);
    cfg_read(8'hE2, rd); chk("R9 no reload while high", rd, 16'h1200);
    cfg_write(8'hE2, 2'b01, 16'hFFFF);
    cfg_read(8'hE2, rd); chk("R2 low lane of E2 ignored", rd, 16'h1200);

    // R9 strap 1 -> all zeros
    cfg_write(8'hE2, 2'b10, 16'hC000);
    @(negedge clk_i); pwr_good_i = 1'b0;
    @(negedge clk_i); pwr_good_i = 1'b1;
    @(negedge clk_i);
    cfg_read(8'hE2, rd); chk("R9 strap1 loads 00", rd, 16'h0000);
    cyc_addr_i = 32'hFFF80000; cyc_is_mem_i = 1'b1; #1;
    chk("R9 cleared no mem hit", fwh_mem_hit_o, 1'b0);

    // R1 asynchronous reset clears both registers
    cfg_write(8'hE6, 2'b11, 16'h0001);
    pwr_good_i = 1'b0;
    #1 rst_ni = 1'b0;
    #1;
    cfg_read(8'hE6, rd); chk("R1 async reset io", rd, 16'h0000);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    cfg_read(8'hE2, rd); chk("R1 after reset fwh", rd, 16'h0000);

    finish_run();
  end
endmodule